// File: doc/BRIEF.md
# JTAG Debug Command Scan Sequencer

This block is a hardware scan master for a debug bridge that sits behind a user data-register chain. A local agent asks for one read or one write of a debug register through a small command port. The block then builds the test clock and the capture, shift and update strobes, and it drives TDI and the chain select. It scans the command frame into the chain and samples TDO. After that it polls the bridge with empty frames until the bridge reports the command finished, reports an error code, or runs out of retries.

The test clock is divided down from the system clock and runs all the time. Every strobe, TDI bit and select change is launched on a falling test-clock edge. TDO is sampled in the system cycle in which the test clock rises, so the sample holds the value present before that edge. Each scan uses a single frame register. Outgoing bits leave from its low end and sampled bits enter at its high end, so that after a full frame the register holds the captured response in the same bit layout as the command.

States: `ST_IDLE` (waits for start), `ST_ALIGN` (waits for the next falling test-clock edge), `ST_SELECT` (select driven for one period), `ST_CAPTURE`, `ST_GAP_A`, `ST_SHIFT` (one period per frame bit), `ST_UPDATE`, `ST_GAP_B` (verdict). Transitions: IDLE→ALIGN on start; ALIGN→SELECT, SELECT→CAPTURE, CAPTURE→GAP_A, GAP_A→SHIFT and UPDATE→GAP_B on each falling edge; SHIFT→UPDATE on the falling edge after the last frame bit; GAP_B→CAPTURE when another poll is needed, GAP_B→IDLE with a done pulse on ok, error or timeout.

Top module: `jtag_cmd_scanner`

## Requirements
- R1: While and after reset, with no start, busy_o, done_o, timeout_o, error_o, capture_o, shift_o, update_o, tdi_o and sel_o are all zero.
- R2: tck_o has a period of TCK_DIV system clocks (default 3), low for TCK_DIV/2 cycles and then high. capture_o, shift_o, update_o, tdi_o and sel_o change only in the cycle in which tck_o falls.
- R3: sel_o equals 4'b0010 (chain 2) from one test-clock period before the first capture of an operation until the operation ends. It is zero while idle, and no strobe is ever raised without it.
- R4: Each scan is, in test-clock periods: capture for one, one idle, shift for exactly 74, update for one, one idle. No two strobes are high at once.
- R5: A command frame has opcode in bits 1:0 (01 read, 10 write), data in bits 65:2 (wdata_i for writes, zero for reads) and address in bits 73:66. It is sent bit 0 first on tdi_o.
- R6: The TDO bit sampled at the k-th shift rising edge becomes bit k of the captured frame.
- R7: Every scan after the command scan shifts an all-zero (no-operation) frame. The status captured by the command scan itself is not acted on.
- R8: A poll response code of 00 ends the operation with a one-cycle done_o and both timeout_o and error_o low. For a read, rdata_o equals captured bits 65:2; for a write it is zero.
- R9: A poll response code of 11 triggers another poll scan, up to 5 polls per command. When the fifth poll also returns 11, done_o is raised with timeout_o high.
- R10: A poll response code of 01 or 10 ends the operation at once with done_o and error_o high, without further polls.
- R11: A start while busy_o is high has no effect. A start while idle clears timeout_o, error_o and rdata_o. Results otherwise hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one command (sampled while idle) |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Debug register address |
| wdata_i | input | 64 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 64 | Read result |
| timeout_o | output | 1 | Retries ran out while the bridge reported busy |
| error_o | output | 1 | Bridge returned an unknown response code |
| tck_o | output | 1 | Divided test clock |
| capture_o | output | 1 | Capture strobe to the chain |
| shift_o | output | 1 | Shift strobe to the chain |
| update_o | output | 1 | Update strobe to the chain |
| tdi_o | output | 1 | Serial data into the chain |
| tdo_i | input | 1 | Serial data out of the chain |
| sel_o | output | 4 | One-hot chain select |

## Verification
The hardest case to reach is the retry limit. A fifth poll that returns busy must end in timeout, while a bridge that turns ready on exactly the fifth poll must still finish cleanly, and only the bridge's response timing separates the two. The bench therefore models the bridge on the test clock with a programmable number of busy captures after each accepted command, and runs four and five busy captures back to back. A forced response code gives the error path. The same model checks the strobe phase of every scan edge, so framing faults in any poll are caught as well as in the command scan.

// File: rtl/jcs_pkg.sv
package jcs_pkg;

    localparam logic [1:0] OPC_READ  = 2'b01;
    localparam logic [1:0] OPC_WRITE = 2'b10;
    localparam logic [1:0] RSP_OK    = 2'b00;
    localparam logic [1:0] RSP_BUSY  = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_SELECT,
        ST_CAPTURE,
        ST_GAP_A,
        ST_SHIFT,
        ST_UPDATE,
        ST_GAP_B
    } jcs_state_e;

    typedef enum logic [1:0] {
        V_AGAIN,
        V_OK,
        V_TIMEOUT,
        V_ERR
    } jcs_verdict_e;

endpackage

// File: rtl/jcs_tck_gen.sv
module jcs_tck_gen #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst,
    output logic tck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LOW = DIV / 2;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    assign rise_o = (cnt_q == CW'(LOW - 1));
    assign fall_o = (cnt_q == CW'(DIV - 1));
    assign cnt_d  = fall_o ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tck_o <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            tck_o <= (cnt_d >= CW'(LOW));
        end
    end

    AST_TCK_RISES: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> tck_o); // R2
    AST_TCK_FALLS: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !tck_o); // R2

endmodule

// File: rtl/jcs_frame_reg.sv
module jcs_frame_reg #(
    parameter int FRAME_W = 74,
    parameter int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_val_i,
    input  logic               smp_i,
    input  logic               shf_i,
    input  logic               tdo_i,
    output logic               tdi_o,
    output logic [1:0]         rsp_code_o,
    output logic [DATA_W-1:0]  rsp_data_o
);
    logic [FRAME_W-1:0] frame_q;
    logic               tdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            tdo_q   <= 1'b0;
        end else begin
            if (smp_i) begin
                tdo_q <= tdo_i;
            end
            if (load_i) begin
                frame_q <= load_val_i;
            end else if (shf_i) begin
                frame_q <= {tdo_q, frame_q[FRAME_W-1:1]};
            end
        end
    end

    assign tdi_o      = frame_q[0];
    assign rsp_code_o = frame_q[1:0];
    assign rsp_data_o = frame_q[DATA_W+1:2];

    always_comb begin
        if (!rst) begin
            AST_LOAD_NOT_SHIFT: assert (!(load_i && shf_i)); // R6
        end
    end

endmodule

// File: rtl/jtag_cmd_scanner.sv
module jtag_cmd_scanner #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 64,
    parameter int TCK_DIV   = 3,
    parameter int MAX_POLLS = 5,
    parameter int SEL_W     = 4,
    parameter int CHAIN     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              timeout_o,
    output logic              error_o,
    output logic              tck_o,
    output logic              capture_o,
    output logic              shift_o,
    output logic              update_o,
    output logic              tdi_o,
    input  logic              tdo_i,
    output logic [SEL_W-1:0]  sel_o
);
    import jcs_pkg::*;

    localparam int FRAME_W = ADDR_W + DATA_W + 2;
    localparam int BCW     = $clog2(FRAME_W);
    localparam int PCW     = $clog2(MAX_POLLS + 1);
    localparam logic [SEL_W-1:0] SEL_MASK = SEL_W'(1) << (CHAIN - 1);

    jcs_state_e   state_q, state_d;
    jcs_verdict_e verdict;

    logic              rise, fall;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              polling_q;
    logic [PCW-1:0]    poll_cnt_q;
    logic [BCW-1:0]    bit_cnt_q;
    logic              last_bit;
    logic              done_q, timeout_q, error_q;
    logic [DATA_W-1:0] rdata_q;

    logic               frm_load;
    logic [FRAME_W-1:0] frm_val;
    logic               frm_tdi;
    logic [1:0]         rsp_code;
    logic [DATA_W-1:0]  rsp_data;

    jcs_tck_gen #(.DIV(TCK_DIV)) tck_i (
        .clk    (clk),
        .rst    (rst),
        .tck_o  (tck_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign frm_load = fall && ((state_q == ST_SELECT) ||
                               (state_q == ST_GAP_B && verdict == V_AGAIN));
    assign frm_val  = (state_q == ST_SELECT) ? {addr_q, data_q, op_q} : '0;

    jcs_frame_reg #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) frame_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (frm_load),
        .load_val_i (frm_val),
        .smp_i      (rise && state_q == ST_SHIFT),
        .shf_i      (fall && state_q == ST_SHIFT),
        .tdo_i      (tdo_i),
        .tdi_o      (frm_tdi),
        .rsp_code_o (rsp_code),
        .rsp_data_o (rsp_data)
    );

    assign last_bit = (bit_cnt_q == BCW'(FRAME_W - 1));

    // Verdict taken at the end of each scan
    always_comb begin
        verdict = V_AGAIN;
        if (polling_q) begin
            unique case (rsp_code)
                RSP_OK:   verdict = V_OK;
                RSP_BUSY: verdict = (poll_cnt_q == PCW'(MAX_POLLS - 1)) ? V_TIMEOUT : V_AGAIN;
                default:  verdict = V_ERR;
            endcase
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ALIGN;
            ST_ALIGN:   if (fall) state_d = ST_SELECT;
            ST_SELECT:  if (fall) state_d = ST_CAPTURE;
            ST_CAPTURE: if (fall) state_d = ST_GAP_A;
            ST_GAP_A:   if (fall) state_d = ST_SHIFT;
            ST_SHIFT:   if (fall && last_bit) state_d = ST_UPDATE;
            ST_UPDATE:  if (fall) state_d = ST_GAP_B;
            ST_GAP_B:   if (fall) state_d = (verdict == V_AGAIN) ? ST_CAPTURE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        capture_o = (state_q == ST_CAPTURE);
        shift_o   = (state_q == ST_SHIFT);
        update_o  = (state_q == ST_UPDATE);
        tdi_o     = (state_q == ST_SHIFT) ? frm_tdi : 1'b0;
        sel_o     = (state_q == ST_IDLE || state_q == ST_ALIGN) ? '0 : SEL_MASK;
    end

    assign done_o    = done_q;
    assign timeout_o = timeout_q;
    assign error_o   = error_q;
    assign rdata_o   = rdata_q;

    // Command latch, counters and results
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q       <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            polling_q  <= 1'b0;
            poll_cnt_q <= '0;
            bit_cnt_q  <= '0;
            done_q     <= 1'b0;
            timeout_q  <= 1'b0;
            error_q    <= 1'b0;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE && start_i) begin
                op_q       <= write_i ? OPC_WRITE : OPC_READ;
                addr_q     <= addr_i;
                data_q     <= write_i ? wdata_i : '0;
                polling_q  <= 1'b0;
                poll_cnt_q <= '0;
                timeout_q  <= 1'b0;
                error_q    <= 1'b0;
                rdata_q    <= '0;
            end
            if (state_q == ST_GAP_A) begin
                bit_cnt_q <= '0;
            end
            if (state_q == ST_SHIFT && fall) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (state_q == ST_GAP_B && fall) begin
                unique case (verdict)
                    V_AGAIN: begin
                        if (polling_q) poll_cnt_q <= poll_cnt_q + 1'b1;
                        polling_q <= 1'b1;
                    end
                    V_OK: begin
                        done_q  <= 1'b1;
                        rdata_q <= (op_q == OPC_READ) ? rsp_data : '0;
                    end
                    V_TIMEOUT: begin
                        done_q    <= 1'b1;
                        timeout_q <= 1'b1;
                    end
                    default: begin
                        done_q  <= 1'b1;
                        error_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({capture_o, shift_o, update_o}) <= 1); // R4
    AST_SHIFT_THEN_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_o) |-> update_o); // R4
    AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        !$stable({capture_o, shift_o, update_o, tdi_o, sel_o}) |-> $fell(tck_o)); // R2
    AST_SEL_COVERS: assert property (@(posedge clk) disable iff (rst)
        (capture_o || shift_o || update_o) |-> (sel_o == SEL_MASK)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        poll_cnt_q < PCW'(MAX_POLLS)); // R9
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(timeout_o && error_o)); // R10
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(addr_q) && $stable(op_q))); // R11

endmodule

// File: tb/jtag_cmd_scanner_tb_top.sv
module jtag_cmd_scanner_tb_top;

    localparam logic [3:0] SEL_EXP = 4'b0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, write = 1'b0;
    logic [7:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic        busy, done, timeout, error;
    logic [63:0] rdata;
    logic        tck, capture, shift, update, tdi, tdo;
    logic [3:0]  sel;

    always #2 clk = ~clk;

    jtag_cmd_scanner dut_i (
        .clk(clk), .rst(rst), .start_i(start), .write_i(write),
        .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .timeout_o(timeout), .error_o(error),
        .tck_o(tck), .capture_o(capture), .shift_o(shift),
        .update_o(update), .tdi_o(tdi), .tdo_i(tdo), .sel_o(sel)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Bridge model on the test clock
    logic [73:0] tsh = '0;
    logic [7:0]  t_addr = '0;
    logic [63:0] t_data = '0;
    logic [63:0] mem [256];
    int  pend = 0, busy_cfg = 0, ph = 0;
    bit  in_scan = 0, frame_bad = 0, force_en = 0;
    logic [1:0] force_code = 2'b00;
    int  n_upd = 0, n_nz = 0, n_cmd = 0;
    logic [1:0]  rec_op = '0;
    logic [7:0]  rec_addr = '0;
    logic [63:0] rec_data = '0;

    assign tdo = tsh[0];

    always @(posedge tck) begin
        if (sel != SEL_EXP) begin
            if (capture || shift || update) frame_bad = 1;
        end else if (capture) begin
            if (in_scan && ph < 77) frame_bad = 1;
            in_scan = 1;
            ph = 0;
            tsh <= {t_addr, t_data, force_en ? force_code : (pend != 0 ? 2'b11 : 2'b00)};
            if (pend != 0) pend--;
        end else if (in_scan) begin
            ph++;
            if (shift != (ph >= 2 && ph <= 75)) frame_bad = 1;
            if (update != (ph == 76)) frame_bad = 1;
            if (shift) tsh <= {tdi, tsh[73:1]};
            if (update) begin
                n_upd++;
                if (tsh != '0) n_nz++;
                if ((tsh[1:0] == 2'b01 || tsh[1:0] == 2'b10) && pend == 0) begin
                    n_cmd++;
                    rec_op   = tsh[1:0];
                    rec_data = tsh[65:2];
                    rec_addr = tsh[73:66];
                    t_addr   = tsh[73:66];
                    if (tsh[1:0] == 2'b10) begin
                        mem[tsh[73:66]] = tsh[65:2];
                        t_data = tsh[65:2];
                    end else begin
                        t_data = mem[tsh[73:66]];
                    end
                    pend = busy_cfg;
                end
            end
        end else if (shift || update) begin
            frame_bad = 1;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tgt_cfg(input int bsy, input bit fen, input logic [1:0] fcode);
        busy_cfg = bsy; force_en = fen; force_code = fcode;
        n_upd = 0; n_nz = 0; n_cmd = 0; frame_bad = 0; in_scan = 0; pend = 0;
    endtask

    task automatic launch(input bit wr, input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        start = 1'b1; write = wr; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done, req, "done seen", done, 1);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !timeout && !error, "R1", "status idle",
            {busy, done, timeout, error}, 0);
        chk(!capture && !shift && !update && !tdi && sel == 0, "R1", "scan pins idle",
            {capture, shift, update, tdi, sel}, 0);
    endtask

    task automatic t_tck;
        int per = 0, low = 0;
        @(posedge tck);
        @(negedge clk);
        per = 1; low = (tck == 1'b0);
        while (!(tck == 1'b0 && 0)) begin
            @(negedge clk);
            if (tck == 1'b1 && low != 0) break;
            per++;
            if (tck == 1'b0) low++;
        end
        chk(per == 3, "R2", "tck period", per, 3);
        chk(low == 1, "R2", "tck low cycles", low, 1);
    endtask

    task automatic t_write_retry;
        tgt_cfg(2, 0, 2'b00);
        launch(1'b1, 8'h5A, 64'hD00D_4321_8765_CAFE);
        chk(busy, "R11", "busy after start", busy, 1);
        wait_done("R8");
        chk(!timeout && !error, "R8", "write clean", {timeout, error}, 0);
        chk(rdata == 64'h0, "R8", "write rdata zero", rdata, 0);
        chk(rec_op == 2'b10 && rec_addr == 8'h5A, "R5", "write op/addr", {rec_op, rec_addr}, {2'b10, 8'h5A});
        chk(rec_data == 64'hD00D_4321_8765_CAFE, "R5", "write data", rec_data, 64'hD00D_4321_8765_CAFE);
        chk(n_upd == 4, "R9", "scans with two busy", n_upd, 4);
        chk(n_nz == 1, "R7", "only command frame nonzero", n_nz, 1);
        chk(!frame_bad, "R4", "scan framing", frame_bad, 0);
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
        chk(sel == 0 && !busy, "R3", "select released", sel, 0);
    endtask

    task automatic t_read_back;
        tgt_cfg(0, 0, 2'b00);
        launch(1'b0, 8'h5A, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_done("R8");
        chk(rdata == 64'hD00D_4321_8765_CAFE, "R6", "read back", rdata, 64'hD00D_4321_8765_CAFE);
        chk(rec_op == 2'b01 && rec_data == 0, "R5", "read frame", {rec_op, rec_data[61:0]}, {2'b01, 62'h0});
        chk(n_upd == 2, "R7", "one poll", n_upd, 2);
    endtask

    task automatic t_last_poll;
        tgt_cfg(4, 0, 2'b00);
        launch(1'b0, 8'hA7, 64'h0);
        wait_done("R9");
        chk(!timeout && !error, "R9", "ready on fifth poll", {timeout, error}, 0);
        chk(rdata == mem[8'hA7], "R8", "read data", rdata, mem[8'hA7]);
        chk(n_upd == 6, "R9", "six scans", n_upd, 6);
        chk(!frame_bad, "R4", "scan framing polls", frame_bad, 0);
    endtask

    task automatic t_timeout;
        tgt_cfg(5, 0, 2'b00);
        launch(1'b1, 8'h03, 64'h1);
        wait_done("R9");
        chk(timeout && !error, "R9", "timeout flag", {timeout, error}, 2'b10);
        chk(n_upd == 6, "R9", "no sixth poll", n_upd, 6);
    endtask

    task automatic t_error(input logic [1:0] code);
        tgt_cfg(0, 1, code);
        launch(1'b0, 8'h10, 64'h0);
        wait_done("R10");
        chk(error && !timeout, "R10", "error flag", {timeout, error}, 2'b01);
        chk(n_upd == 2, "R10", "no retry on error", n_upd, 2);
    endtask

    task automatic t_hold_and_ignore;
        repeat (40) @(negedge clk);
        chk(error, "R11", "error held while idle", error, 1);
        tgt_cfg(1, 0, 2'b00);
        launch(1'b1, 8'h11, 64'h0123_4567_89AB_CDEF);
        chk(!error && !timeout, "R11", "status cleared by start", {timeout, error}, 0);
        repeat (100) @(negedge clk);
        start = 1'b1; write = 1'b0; addr = 8'h22; wdata = '0;
        @(negedge clk);
        start = 1'b0;
        wait_done("R11");
        chk(n_cmd == 1 && rec_addr == 8'h11, "R11", "start while busy ignored", {n_cmd[7:0], rec_addr}, {8'd1, 8'h11});
        repeat (300) @(negedge clk);
        chk(!busy && n_upd == 3, "R11", "no second operation", {busy, n_upd[7:0]}, {1'b0, 8'd3});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0], 48'h3C5A_96E1_0F72 ^ 48'(i * 7)};
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tck();
        t_write_retry();
        t_read_back();
        t_last_poll();
        t_timeout();
        t_error(2'b01);
        t_error(2'b10);
        t_hold_and_ignore();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule